// File: doc/BRIEF.md
# LCD Display Data Scan Controller

This block turns the contents of a display memory into per-line segment data for a multiplexed LCD. Each tick from the LCD clock enable starts one common line. The block reads one memory word per segment through a synchronous read port. It picks the bit of each word that belongs to the current common line and latches the results. When the whole line is assembled, it presents the segment vector for one cycle, together with the index of the active common. Analog drive and waveform shaping are handled elsewhere.

An 8-bit control register sets how memory is mapped onto the glass:
- segment order, ascending or descending;
- common order, ascending or descending;
- which of two memory areas is shown;
- pixel inversion;
- a display mode: off, normal, forced all-on or forced all-off.

Software writes into a pending copy of the register. The scanner copies that into its working settings only when a frame starts, that is, at the start of common line 0. A frame therefore never mixes old and new settings.

Top module: `lcd_scan_ctrl`

## Requirements
- R1: Control bit 7 set to 1 makes segment output s take memory word s of the area. Set to 0, it takes word NUM_SEG-1-s.
- R2: Control bit 6 set to 1 makes common line c use bit c of each word. Set to 0, it uses bit NUM_COM-1-c.
- R3: Control bit 5 selects the memory area. The words of area k sit at addresses k*NUM_SEG to k*NUM_SEG+NUM_SEG-1.
- R4: Control bit 4 set to 0 inverts every pixel taken from memory. Set to 1, pixels pass unchanged.
- R5: Control bits 1:0 select the display mode:
  - 0 forces all segments to 0 and drives disp_active low;
  - 1 shows memory data;
  - 2 forces all segments to 1;
  - 3 forces all segments to 0.
  
  Modes 2 and 3 override both memory data and inversion. disp_active is high for modes 1, 2 and 3.
- R6: The register resets to 0xD0. Bits 3:2 ignore writes and always read as 0. Reads return the last value written.
- R7: A tick starts a line only while scan_en is 1. With scan_en at 0, no memory read and no line strobe occur.
- R8: A register write reaches the scanned output only from the next line that has common index 0 onward. Lines already inside the current frame keep the earlier settings.
- R9: A tick sampled on an idle clock edge triggers the following, in order:
  - exactly NUM_SEG memory reads;
  - a one-cycle line_valid, high after the NUM_SEG+2-th rising edge counted from that edge;
  - the common index then advances by one and wraps from NUM_COM-1 to 0.
  
  A tick that arrives while a line is still being built is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_wr | input | 1 | Control register write strobe |
| reg_wdata | input | 8 | Control register write data |
| reg_rdata | output | 8 | Control register read data (pending copy) |
| scan_en | input | 1 | LCD clock enable; scanning stops while 0 |
| tick | input | 1 | One-cycle line start pulse from the clock enable |
| mem_rd | output | 1 | Display memory read request |
| mem_addr | output | ADDR_W | Display memory word address |
| mem_rdata | input | NUM_COM | Word returned one cycle after the request |
| line_valid | output | 1 | One-cycle strobe: line_seg and line_com are valid |
| line_seg | output | NUM_SEG | Segment data for the active common line |
| line_com | output | COM_W | Index of the active common line |
| disp_active | output | 1 | High unless the working mode is display off |

## Verification
The bench fills the memory model with a word pattern that differs at every address and in every bit. Any wrong mapping therefore shows up as a wrong segment vector.

The control table runs a full frame for each of the following settings:
- the default mapping;
- each order bit reversed on its own;
- area 1;
- inversion alone;
- everything reversed together;
- each forced mode combined with inversion.

Comparing every line against the default mapping separates segment mirroring from common mirroring, from area selection and from inversion. The forced-mode rows show whether those modes really override inversion.

A directed sequence writes the register halfway through a frame. This tells apart an update at the frame boundary from an immediate one.

// File: rtl/lcd_scan_pkg.sv
package lcd_scan_pkg;

  typedef enum logic [1:0] {
    MODE_OFF     = 2'd0,
    MODE_NORMAL  = 2'd1,
    MODE_ALL_ON  = 2'd2,
    MODE_ALL_OFF = 2'd3
  } disp_mode_e;

  typedef struct packed {
    logic       seg_asc;
    logic       com_asc;
    logic       area_sel;
    logic       pix_pass;
    logic [1:0] rsvd;
    disp_mode_e mode;
  } scan_cfg_t;

  localparam logic [7:0] CFG_RESET = 8'hD0;

  // Index after optional mirroring across n positions.
  function automatic int mirror_idx(input int i, input int n, input logic asc);
    return asc ? i : (n - 1 - i);
  endfunction

  // Word address of a segment inside the selected area.
  function automatic int word_addr(input int seg, input int nseg, input logic asc,
                                   input logic area);
    return (area ? nseg : 0) + mirror_idx(seg, nseg, asc);
  endfunction

endpackage

// File: rtl/lcd_cfg_reg.sv
module lcd_cfg_reg
  import lcd_scan_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       wr,
  input  logic [7:0] wdata,
  input  logic       frame_load,
  output logic [7:0] rdata,
  output scan_cfg_t  active
);

  logic [7:0] pending_q;
  logic [7:0] active_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pending_q <= CFG_RESET;
    end else if (wr) begin
      pending_q <= {wdata[7:4], 2'b00, wdata[1:0]};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active_q <= CFG_RESET;
    end else if (frame_load) begin
      active_q <= pending_q;
    end
  end

  assign rdata  = pending_q;
  assign active = scan_cfg_t'(active_q);

  // R6: reserved bits never read back as 1
  p_rsvd_zero_r6: assert property (@(posedge clk) disable iff (!rst_n)
    rdata[3:2] == 2'b00);

  // R8: working settings move only at a frame start
  p_active_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !frame_load |=> $stable(active_q));

endmodule

// File: rtl/lcd_line_seq.sv
module lcd_line_seq #(
  parameter int NUM_SEG = 8,
  parameter int NUM_COM = 8,
  localparam int SEG_W = (NUM_SEG > 1) ? $clog2(NUM_SEG) : 1,
  localparam int COM_W = (NUM_COM > 1) ? $clog2(NUM_COM) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             scan_en,
  input  logic             tick,
  output logic             rd_req,
  output logic [SEG_W-1:0] rd_seg,
  output logic             line_done,
  output logic             frame_load,
  output logic [COM_W-1:0] com_idx
);

  typedef enum logic [1:0] {S_IDLE, S_READ, S_DRAIN, S_DONE} seq_e;

  localparam logic [SEG_W-1:0] SEG_LAST = SEG_W'(NUM_SEG - 1);
  localparam logic [COM_W-1:0] COM_LAST = COM_W'(NUM_COM - 1);

  seq_e             state_q;
  logic [SEG_W-1:0] seg_q;
  logic [COM_W-1:0] com_q;
  logic             line_start;

  assign line_start = (state_q == S_IDLE) && tick && scan_en;
  assign frame_load = line_start && (com_q == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= S_IDLE;
      seg_q   <= '0;
      com_q   <= '0;
    end else begin
      case (state_q)
        S_IDLE: if (line_start) begin
          state_q <= S_READ;
          seg_q   <= '0;
        end
        S_READ: begin
          if (seg_q == SEG_LAST) state_q <= S_DRAIN;
          else                   seg_q   <= seg_q + 1'b1;
        end
        S_DRAIN: state_q <= S_DONE;
        default: begin
          state_q <= S_IDLE;
          com_q   <= (com_q == COM_LAST) ? '0 : com_q + 1'b1;
        end
      endcase
    end
  end

  assign rd_req    = (state_q == S_READ);
  assign rd_seg    = seg_q;
  assign line_done = (state_q == S_DONE);
  assign com_idx   = com_q;

  // R9: line strobe lasts exactly one cycle
  p_valid_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
    line_done |=> !line_done);

  // R9: common index wraps after the last line
  p_com_wrap_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (line_done && com_q == COM_LAST) |=> (com_q == '0));

  // R7: no line starts while scanning is disabled
  p_no_scan_off_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == S_IDLE && !scan_en) |=> (state_q == S_IDLE));

endmodule

// File: rtl/lcd_seg_assemble.sv
module lcd_seg_assemble
  import lcd_scan_pkg::*;
#(
  parameter int NUM_SEG = 8,
  parameter int NUM_COM = 8,
  localparam int SEG_W = (NUM_SEG > 1) ? $clog2(NUM_SEG) : 1,
  localparam int COM_W = (NUM_COM > 1) ? $clog2(NUM_COM) : 1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               rd_req,
  input  logic [SEG_W-1:0]   rd_seg,
  input  logic [NUM_COM-1:0] mem_rdata,
  input  logic [COM_W-1:0]   bit_sel,
  input  scan_cfg_t          cfg,
  input  logic               line_done,
  output logic [NUM_SEG-1:0] seg_out,
  output logic               disp_active
);

  logic               pend_q;
  logic [SEG_W-1:0]   pend_seg_q;
  logic [NUM_SEG-1:0] pix_q;
  logic               pix_new;

  assign pix_new = mem_rdata[bit_sel] ^ ~cfg.pix_pass;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q     <= 1'b0;
      pend_seg_q <= '0;
      pix_q      <= '0;
    end else begin
      pend_q     <= rd_req;
      pend_seg_q <= rd_seg;
      if (pend_q) pix_q[pend_seg_q] <= pix_new;
    end
  end

  always_comb begin
    case (cfg.mode)
      MODE_NORMAL: seg_out = pix_q;
      MODE_ALL_ON: seg_out = '1;
      default:     seg_out = '0;
    endcase
  end

  assign disp_active = (cfg.mode != MODE_OFF);

  // R5: display off blanks the line and drops the active flag
  p_off_blank_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (line_done && cfg.mode == MODE_OFF) |-> (seg_out == '0 && !disp_active));

  // R5: forced all-on ignores the memory data and inversion
  p_all_on_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (line_done && cfg.mode == MODE_ALL_ON) |-> (seg_out == '1));

endmodule

// File: rtl/lcd_scan_ctrl.sv
module lcd_scan_ctrl
  import lcd_scan_pkg::*;
#(
  parameter int NUM_SEG = 8,
  parameter int NUM_COM = 8,
  localparam int ADDR_W = $clog2(2 * NUM_SEG),
  localparam int SEG_W  = (NUM_SEG > 1) ? $clog2(NUM_SEG) : 1,
  localparam int COM_W  = (NUM_COM > 1) ? $clog2(NUM_COM) : 1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               reg_wr,
  input  logic [7:0]         reg_wdata,
  output logic [7:0]         reg_rdata,
  input  logic               scan_en,
  input  logic               tick,
  output logic               mem_rd,
  output logic [ADDR_W-1:0]  mem_addr,
  input  logic [NUM_COM-1:0] mem_rdata,
  output logic               line_valid,
  output logic [NUM_SEG-1:0] line_seg,
  output logic [COM_W-1:0]   line_com,
  output logic               disp_active
);

  scan_cfg_t        cfg;
  logic             frame_load;
  logic             rd_req;
  logic [SEG_W-1:0] rd_seg;
  logic             line_done;
  logic [COM_W-1:0] com_idx;
  logic [COM_W-1:0] bit_sel;

  lcd_cfg_reg u_cfg (
    .clk        (clk),
    .rst_n      (rst_n),
    .wr         (reg_wr),
    .wdata      (reg_wdata),
    .frame_load (frame_load),
    .rdata      (reg_rdata),
    .active     (cfg)
  );

  lcd_line_seq #(.NUM_SEG(NUM_SEG), .NUM_COM(NUM_COM)) u_seq (
    .clk        (clk),
    .rst_n      (rst_n),
    .scan_en    (scan_en),
    .tick       (tick),
    .rd_req     (rd_req),
    .rd_seg     (rd_seg),
    .line_done  (line_done),
    .frame_load (frame_load),
    .com_idx    (com_idx)
  );

  assign mem_rd   = rd_req;
  assign mem_addr = ADDR_W'(word_addr(int'(rd_seg), NUM_SEG, cfg.seg_asc, cfg.area_sel));
  assign bit_sel  = COM_W'(mirror_idx(int'(com_idx), NUM_COM, cfg.com_asc));

  lcd_seg_assemble #(.NUM_SEG(NUM_SEG), .NUM_COM(NUM_COM)) u_asm (
    .clk         (clk),
    .rst_n       (rst_n),
    .rd_req      (rd_req),
    .rd_seg      (rd_seg),
    .mem_rdata   (mem_rdata),
    .bit_sel     (bit_sel),
    .cfg         (cfg),
    .line_done   (line_done),
    .seg_out     (line_seg),
    .disp_active (disp_active)
  );

  assign line_valid = line_done;
  assign line_com   = com_idx;

  // R3: every address stays inside the selected area
  p_area_range_r3: assert property (@(posedge clk) disable iff (!rst_n)
    mem_rd |-> ((int'(mem_addr) >= (cfg.area_sel ? NUM_SEG : 0)) &&
                (int'(mem_addr) <  (cfg.area_sel ? 2 * NUM_SEG : NUM_SEG))));

  // R9: no read is issued while the line strobe is up
  p_no_read_at_valid_r9: assert property (@(posedge clk) disable iff (!rst_n)
    line_valid |-> !mem_rd);

endmodule

// File: tb/lcd_scan_ctrl_test.sv
`timescale 1ns/1ps
module lcd_scan_ctrl_test;

  localparam int NS = 8;
  localparam int NC = 8;
  localparam int AW = $clog2(2 * NS);
  localparam int CW = $clog2(NC);

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          reg_wr = 1'b0;
  logic [7:0]    reg_wdata = '0;
  logic [7:0]    reg_rdata;
  logic          scan_en = 1'b1;
  logic          tick = 1'b0;
  logic          mem_rd;
  logic [AW-1:0] mem_addr;
  logic [NC-1:0] mem_rdata;
  logic          line_valid;
  logic [NS-1:0] line_seg;
  logic [CW-1:0] line_com;
  logic          disp_active;

  int checks = 0;
  int fails  = 0;
  int rd_count = 0;

  always #2.5 clk = ~clk;

  lcd_scan_ctrl #(.NUM_SEG(NS), .NUM_COM(NC)) uut (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .scan_en(scan_en), .tick(tick), .mem_rd(mem_rd),
    .mem_addr(mem_addr), .mem_rdata(mem_rdata), .line_valid(line_valid),
    .line_seg(line_seg), .line_com(line_com), .disp_active(disp_active)
  );

  function automatic logic [NC-1:0] mem_word(input int a);
    return NC'((a * 29 + 11) ^ 8'h5A);
  endfunction

  always_ff @(posedge clk) begin
    if (mem_rd) begin
      mem_rdata <= mem_word(int'(mem_addr));
      rd_count  <= rd_count + 1;
    end
  end

  // Expected line from the requirements.
  function automatic logic [NS-1:0] expect_line(input logic [7:0] cfg, input int c);
    logic [NS-1:0] v;
    for (int s = 0; s < NS; s++) begin
      int w = (cfg[5] ? NS : 0) + (cfg[7] ? s : NS - 1 - s);
      int b = cfg[6] ? c : NC - 1 - c;
      logic [NC-1:0] word = mem_word(w);
      v[s] = word[b] ^ ~cfg[4];
    end
    case (cfg[1:0])
      2'd1:    return v;
      2'd2:    return '1;
      default: return '0;
    endcase
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic write_cfg(input logic [7:0] v);
    @(negedge clk);
    reg_wr = 1'b1; reg_wdata = v;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  // Pulses tick and waits for the line strobe; returns latency in edges.
  task automatic run_line(output int lat, output logic [NS-1:0] seg, output int com);
    @(negedge clk);
    tick = 1'b1;
    @(negedge clk);
    tick = 1'b0;
    lat = 1;
    while (!line_valid && lat < 50) begin
      @(negedge clk);
      lat++;
    end
    seg = line_seg;
    com = int'(line_com);
    @(negedge clk);
  endtask

  typedef struct packed { logic [7:0] cfg; logic [7:0] req; } vec_t;
  localparam int NV = 10;
  localparam vec_t VECS [NV] = '{
    '{8'hD1, 8'd1},  // R1 baseline ascending
    '{8'h51, 8'd1},  // R1 segment order descending
    '{8'h91, 8'd2},  // R2 common order descending
    '{8'hF1, 8'd3},  // R3 area 1
    '{8'hC1, 8'd4},  // R4 inversion
    '{8'h01, 8'd4},  // R4 everything reversed and inverted
    '{8'hC2, 8'd5},  // R5 all on overrides inversion
    '{8'hD3, 8'd5},  // R5 all off
    '{8'hC3, 8'd5},  // R5 all off overrides inversion
    '{8'hE0, 8'd5}   // R5 display off
  };

  initial begin
    int lat;
    int com;
    int rd0;
    logic [NS-1:0] seg;
    logic [7:0] cur;

    mem_rdata = '0;
    repeat (3) @(negedge clk);
    // R6 reset state
    check("R6 reset value", 32'(reg_rdata), 32'hD0);
    check("R5 reset display off", 32'(disp_active), 32'h0);
    check("R9 reset strobe", 32'(line_valid), 32'h0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R9 reset common", 32'(line_com), 32'h0);

    write_cfg(8'hFF);
    check("R6 reserved bits read 0", 32'(reg_rdata), 32'hF3);

    for (int v = 0; v < NV; v++) begin
      cur = VECS[v].cfg;
      write_cfg(cur);
      for (int c = 0; c < NC; c++) begin
        rd0 = rd_count;
        run_line(lat, seg, com);
        check($sformatf("R9 common index v%0d", v), 32'(com), 32'(c));
        check($sformatf("R%0d line v%0d c%0d", VECS[v].req, v, c),
              32'(seg), 32'(expect_line(cur, c)));
        if (v == 0 && c == 0) begin
          check("R9 latency", 32'(lat), 32'(NS + 2));
          check("R9 reads per line", 32'(rd_count - rd0), 32'(NS));
        end
      end
      check($sformatf("R5 disp_active v%0d", v), 32'(disp_active),
            32'(cur[1:0] != 2'd0));
    end

    // R8 mid-frame write
    write_cfg(8'hD1);
    for (int c = 0; c < NC; c++) run_line(lat, seg, com);
    for (int c = 0; c < 4; c++) run_line(lat, seg, com);
    write_cfg(8'hC1);
    for (int c = 4; c < NC; c++) begin
      run_line(lat, seg, com);
      check("R8 old settings hold in frame", 32'(seg), 32'(expect_line(8'hD1, c)));
    end
    run_line(lat, seg, com);
    check("R8 new settings at frame start", 32'(seg), 32'(expect_line(8'hC1, 0)));
    for (int c = 1; c < NC; c++) run_line(lat, seg, com);

    // R7 scan disabled
    scan_en = 1'b0;
    rd0 = rd_count;
    begin
      int seen = 0;
      @(negedge clk);
      tick = 1'b1;
      @(negedge clk);
      tick = 1'b0;
      repeat (2 * NS) begin
        @(negedge clk);
        if (line_valid) seen++;
      end
      check("R7 no strobe while disabled", 32'(seen), 32'h0);
      check("R7 no reads while disabled", 32'(rd_count - rd0), 32'h0);
      check("R7 common held", 32'(line_com), 32'h0);
    end
    scan_en = 1'b1;
    run_line(lat, seg, com);
    check("R7 scan resumes", 32'(com), 32'h0);

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    #(5ns * 150000);
    checks++;
    fails++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule